// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

The block gathers a large set of raw interrupt lines, 256 by default, and reports them to a host through a small byte-wide register window. The lines form groups of eight called blocks. Eight blocks form a master. A root byte shows which masters hold anything pending. The host follows the tree downward: it reads the root, then a master's byte, then selects a block and reads that block's pending byte. One summary interrupt output tells the host when to begin.

Each line has its own configuration. It can detect a rising edge, a falling edge or both, or it can act as an active-high or active-low level. Each line can be masked, and its pending latch can be cleared. The host writes a single byte to configure a line. That byte carries the line's index inside the currently selected block and a write-enable flag. The host can also read the live levels of the selected block's eight lines, whatever the configuration or pending state.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset every line is masked on both polarities and in edge mode, nothing is pending, the block select is 0, `irq_o` is low, and `rd_data_o` is 0.
- R2: The window starts at address 0x1BB and uses these offsets: +0 root, +1 to +4 master status 0 to 3, +5 block select (read and write), +6 block pending, +7 line config (write only, reads 0), +8 block live levels. Any other address reads 0. `rd_data_o` is loaded on the clock edge where `rd_en_i` is high and holds its value at all other times.
- R3: In the root byte, bit 0 is always 0, bit m+1 is set when master m has any pending line, and the unused upper bits are 0.
- R4: Bit i of master status m is set when block m*8+i has at least one pending line.
- R5: Bit i of the block pending byte is the pending state of line sel*8+i. Bit i of the live byte is the raw level of line sel*8+i, independent of masks and latches.
- R6: A config byte written to +7 takes effect only when bit 7 is 1. Bits 6:4 select the line inside the selected block. Bit 3 clears the pending latch. Bit 2 masks the rising edge or high level. Bit 1 masks the falling edge or low level. Bit 0 selects level mode. A config write with bit 7 at 0 changes nothing.
- R7: In edge mode, an unmasked rising edge or falling edge (the input differs from its value one cycle earlier) sets the pending latch at that clock edge. The latch stays set until a config write with the clear bit set. Both edges may be enabled at the same time.
- R8: In level mode, the pending bit follows the unmasked active level with a delay of one clock: it is high while the input sits at an unmasked active level and low otherwise.
- R9: A line whose active edge or level is masked never sets its pending bit.
- R10: When an enabled edge and a clear arrive in the same cycle, the pending bit stays set.
- R11: `irq_o` is high exactly when any line is pending, and it follows the pending state with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 256 | Raw interrupt lines, already synchronous to clk_i |
| addr_i | input | 10 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Summary interrupt to the host |

## Verification
A pending latch held in the wrong state drives `irq_o` wrong right after the edge that sets it. The same fault shows in the root, master and block bytes at the next read. A mis-decoded configuration byte, such as one missing the write-enable flag or carrying the wrong mask polarity, is only visible when a later input transition fails to set pending or sets it unexpectedly. For that reason each mode is exercised with a sequence of input levels, and the pending state is read after every step. A wrong block select gives the wrong live byte on the very next read, and masks have no effect on that byte.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LPB    = 8;  // lines per block, one byte of status

  // offsets from window base
  localparam int unsigned OFF_ROOT = 0;
  localparam int unsigned OFF_MST0 = 1;
  localparam int unsigned OFF_SEL  = 5;
  localparam int unsigned OFF_PEND = 6;
  localparam int unsigned OFF_CFG  = 7;
  localparam int unsigned OFF_LIVE = 8;

  // config byte fields
  localparam int unsigned CB_LVL     = 0;
  localparam int unsigned CB_MASK_FE = 1;
  localparam int unsigned CB_MASK_RE = 2;
  localparam int unsigned CB_CLR     = 3;
  localparam int unsigned CB_IDX     = 4;
  localparam int unsigned CB_WE      = 7;

  typedef struct packed {
    logic lvl;
    logic mask_re;
    logic mask_fe;
  } line_cfg_t;

  localparam line_cfg_t CFG_RST = '{lvl: 1'b0, mask_re: 1'b1, mask_fe: 1'b1};
endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_tree_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      line_i,
  input  logic      cfg_we_i,
  input  line_cfg_t cfg_i,
  input  logic      clr_i,
  output logic      pend_o
);
  logic      prev_q;
  logic      pend_q;
  line_cfg_t cfg_q;
  logic      rise, fall, edge_hit, lvl_hit;

  assign rise     = line_i & ~prev_q;
  assign fall     = ~line_i & prev_q;
  assign edge_hit = (rise & ~cfg_q.mask_re) | (fall & ~cfg_q.mask_fe);
  assign lvl_hit  = (line_i & ~cfg_q.mask_re) | (~line_i & ~cfg_q.mask_fe);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cfg_q  <= CFG_RST;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      if (cfg_we_i) cfg_q <= cfg_i;
      if (cfg_q.lvl)     pend_q <= lvl_hit;
      else if (edge_hit) pend_q <= 1'b1;  // new edge beats clear
      else if (clr_i)    pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_summary_tree.sv
module irq_summary_tree
  import irq_tree_pkg::*;
#(
  parameter int unsigned NUM_LINES = 256,
  parameter int unsigned BPM       = 8,
  localparam int unsigned NUM_BLKS = NUM_LINES / LPB,
  localparam int unsigned NUM_MST  = NUM_BLKS / BPM
) (
  input  logic [NUM_LINES-1:0] pend_i,
  output logic [NUM_BLKS-1:0]  blk_any_o,
  output logic [NUM_MST-1:0]   mst_any_o,
  output logic                 irq_o
);
  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
    assign blk_any_o[b] = |pend_i[b*LPB +: LPB];
  end
  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    assign mst_any_o[m] = |blk_any_o[m*BPM +: BPM];
  end
  assign irq_o = |mst_any_o;
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_tree_pkg::*;
#(
  parameter int unsigned NUM_LINES = 256,
  parameter int unsigned BPM       = 8,
  parameter int unsigned ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h1BB,
  localparam int unsigned NUM_BLKS = NUM_LINES / LPB,
  localparam int unsigned NUM_MST  = NUM_BLKS / BPM,
  localparam int unsigned SEL_W    = $clog2(NUM_BLKS),
  localparam int unsigned IDX_W    = $clog2(LPB),
  localparam int unsigned LINE_W   = SEL_W + IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [BYTE_W-1:0]    wr_data_i,
  input  logic                 rd_en_i,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_BLKS-1:0]  blk_any_i,
  input  logic [NUM_MST-1:0]   mst_any_i,
  output logic [BYTE_W-1:0]    rd_data_o,
  output logic [NUM_LINES-1:0] cfg_we_o,
  output logic [NUM_LINES-1:0] cfg_clr_o,
  output line_cfg_t            cfg_val_o,
  output logic [SEL_W-1:0]     sel_o
);
  logic [ADDR_W-1:0] off;
  logic [SEL_W-1:0]  sel_q;
  logic [BYTE_W-1:0] rd_q, rd_mux;
  logic [LINE_W-1:0] tgt;
  logic              cfg_hit;

  assign off     = addr_i - BASE_ADDR;
  assign cfg_hit = wr_en_i && (off == ADDR_W'(OFF_CFG)) && wr_data_i[CB_WE];
  assign tgt     = {sel_q, wr_data_i[CB_IDX +: IDX_W]};

  assign cfg_we_o  = cfg_hit ? (NUM_LINES'(1) << tgt) : '0;
  assign cfg_clr_o = cfg_we_o & {NUM_LINES{wr_data_i[CB_CLR]}};
  assign cfg_val_o = '{lvl:     wr_data_i[CB_LVL],
                       mask_re: wr_data_i[CB_MASK_RE],
                       mask_fe: wr_data_i[CB_MASK_FE]};

  always_comb begin
    rd_mux = '0;
    if (off == ADDR_W'(OFF_ROOT)) rd_mux = BYTE_W'({mst_any_i, 1'b0});
    if (off == ADDR_W'(OFF_SEL))  rd_mux = BYTE_W'(sel_q);
    if (off == ADDR_W'(OFF_PEND)) rd_mux = pend_i[int'(sel_q)*LPB +: LPB];
    if (off == ADDR_W'(OFF_LIVE)) rd_mux = line_i[int'(sel_q)*LPB +: LPB];
    for (int m = 0; m < NUM_MST; m++) begin
      if (off == ADDR_W'(OFF_MST0 + m)) rd_mux = blk_any_i[m*BPM +: BPM];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      rd_q  <= '0;
    end else begin
      if (wr_en_i && (off == ADDR_W'(OFF_SEL))) sel_q <= wr_data_i[SEL_W-1:0];
      if (rd_en_i) rd_q <= rd_mux;
    end
  end

  assign rd_data_o = rd_q;
  assign sel_o     = sel_q;
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int unsigned NUM_LINES = 256,
  parameter int unsigned BPM       = 8,
  parameter int unsigned ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h1BB,
  localparam int unsigned NUM_BLKS = NUM_LINES / LPB,
  localparam int unsigned NUM_MST  = NUM_BLKS / BPM,
  localparam int unsigned SEL_W    = $clog2(NUM_BLKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [BYTE_W-1:0]    wr_data_i,
  input  logic                 rd_en_i,
  output logic [BYTE_W-1:0]    rd_data_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] cfg_we, cfg_clr, pend;
  logic [NUM_BLKS-1:0]  blk_any;
  logic [NUM_MST-1:0]   mst_any;
  logic [SEL_W-1:0]     blk_sel;
  line_cfg_t            cfg_val;

  irq_reg_if #(
    .NUM_LINES(NUM_LINES), .BPM(BPM), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_data_i, .rd_en_i, .line_i,
    .pend_i(pend), .blk_any_i(blk_any), .mst_any_i(mst_any),
    .rd_data_o, .cfg_we_o(cfg_we), .cfg_clr_o(cfg_clr),
    .cfg_val_o(cfg_val), .sel_o(blk_sel)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    irq_line_cell u_cell (
      .clk_i, .rst_ni, .line_i(line_i[l]), .cfg_we_i(cfg_we[l]),
      .cfg_i(cfg_val), .clr_i(cfg_clr[l]), .pend_o(pend[l])
    );
  end

  irq_summary_tree #(.NUM_LINES(NUM_LINES), .BPM(BPM)) u_tree (
    .pend_i(pend), .blk_any_o(blk_any), .mst_any_o(mst_any), .irq_o
  );
endmodule

// File: rtl/irq_tree_ctrl_chk.sv
module irq_tree_ctrl_chk
  import irq_tree_pkg::*;
#(
  parameter int unsigned NUM_LINES = 256,
  parameter int unsigned SEL_W     = 5,
  parameter int unsigned ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h1BB
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] line_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 wr_en_i,
  input logic [BYTE_W-1:0]    wr_data_i,
  input logic                 rd_en_i,
  input logic [BYTE_W-1:0]    rd_data_o,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] cfg_we,
  input logic [NUM_LINES-1:0] pend,
  input logic [SEL_W-1:0]     blk_sel
);
  logic [BYTE_W-1:0] live_blk;
  assign live_blk = line_i[int'(blk_sel)*LPB +: LPB];

  assert_root_bit0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == BASE_ADDR |=> !rd_data_o[0]);

  assert_read_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  assert_no_we_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == BASE_ADDR + ADDR_W'(OFF_CFG) && !wr_data_i[CB_WE]
      |-> cfg_we == '0);

  assert_cfg_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_we));

  assert_live_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == BASE_ADDR + ADDR_W'(OFF_LIVE) |=> rd_data_o == $past(live_blk));

  assert_irq_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend == '0 |-> !irq_o);

  assert_irq_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend != '0 |-> irq_o);
endmodule

bind irq_tree_ctrl irq_tree_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i, .rst_ni, .line_i, .addr_i, .wr_en_i, .wr_data_i, .rd_en_i,
  .rd_data_o, .irq_o, .cfg_we, .pend, .blk_sel
);

// File: tb/irq_tree_ctrl_tb.sv
module irq_tree_ctrl_tb;
  localparam int CLK_NS = 4;
  localparam logic [9:0] B = 10'h1BB;

  // {cfg[2:0] = {mask_re, mask_fe, lvl}, line seq (msb first), expected pending}
  localparam logic [8:0] VEC [7] = '{
    9'b010_010_011,  // rising only
    9'b100_101_011,  // falling only
    9'b000_110_111,  // both edges
    9'b110_101_000,  // edge, fully masked
    9'b011_101_101,  // level high
    9'b101_100_011,  // level low
    9'b111_101_000   // level, masked
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] lines = '0;
  logic [9:0]   addr = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         irq;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  irq_tree_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(lines), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wdata), .rd_en_i(rd_en),
    .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(posedge clk); #1; rd_en = 1'b0; d = rdata;
  endtask

  task automatic set_line(input int idx, input logic v);
    @(negedge clk); lines[idx] = v;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    // R1: reset state
    chk("R1 rd_data", rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    for (int o = 0; o < 9; o++) begin
      rd(B + 10'(o), v);
      chk($sformatf("R1 offset %0d", o), v, 8'h00);
    end

    // table walk: line 29 = block 3, index 5
    wr(B + 10'd5, 8'h03);
    foreach (VEC[k]) begin
      set_line(29, 1'b0);
      idle(2);
      wr(B + 10'd7, 8'h80 | 8'h08 | 8'h50 | {5'b0, VEC[k][8:6]});
      for (int s = 0; s < 3; s++) begin
        set_line(29, VEC[k][5 - s]);
        // R11: irq follows pending directly; R7 R8 R9 per vector
        chk($sformatf("R11 irq vec%0d step%0d", k, s), {7'b0, irq}, {7'b0, VEC[k][2 - s]});
        rd(B + 10'd6, v);
        chk($sformatf("R7 R8 R9 pend vec%0d step%0d", k, s), v, {2'b0, VEC[k][2 - s], 5'b0});
      end
    end

    // R6: config write without enable bit is ignored (would enable rising edge)
    wr(B + 10'd7, 8'h52);
    set_line(29, 1'b0);
    set_line(29, 1'b1);
    rd(B + 10'd6, v);
    chk("R6 no-enable write ignored", v, 8'h00);
    chk("R6 irq stays low", {7'b0, irq}, 8'h00);

    // R2: select readback, config reads 0, out-of-window reads 0
    rd(B + 10'd5, v);  chk("R2 select readback", v, 8'h03);
    rd(B + 10'd7, v);  chk("R2 config reads 0", v, 8'h00);
    rd(B + 10'd9, v);  chk("R2 above window", v, 8'h00);
    rd(B - 10'd1, v);  chk("R2 below window", v, 8'h00);

    // R5: live levels regardless of masks
    @(negedge clk); lines[31:24] = 8'hA5;
    rd(B + 10'd8, v);  chk("R5 live byte", v, 8'hA5);
    rd(B + 10'd6, v);  chk("R9 masked block pending", v, 8'h00);
    rd(B + 10'd8, v);
    @(negedge clk); lines[31:24] = 8'h5A;
    idle(2);
    chk("R2 read data holds", rdata, 8'hA5);
    @(negedge clk); lines[31:24] = 8'h00;

    // R3 R4: line 250 = block 31 index 2, master 3 bit 7, root bit 4
    wr(B + 10'd5, 8'd31);
    wr(B + 10'd7, 8'hAA);
    set_line(250, 1'b1);
    chk("R11 irq on edge", {7'b0, irq}, 8'h01);
    rd(B + 10'd0, v);  chk("R3 root", v, 8'h10);
    rd(B + 10'd4, v);  chk("R4 master 3", v, 8'h80);
    rd(B + 10'd1, v);  chk("R4 master 0 empty", v, 8'h00);
    rd(B + 10'd6, v);  chk("R5 block pending", v, 8'h04);
    rd(B + 10'd8, v);  chk("R5 block live", v, 8'h04);

    // R7: latch holds after input drops, clear releases it
    set_line(250, 1'b0);
    idle(2);
    rd(B + 10'd6, v);  chk("R7 latch held", v, 8'h04);
    wr(B + 10'd7, 8'hAA);
    rd(B + 10'd6, v);  chk("R7 cleared", v, 8'h00);

    // R10: edge and clear in the same cycle
    @(negedge clk); lines[250] = 1'b1; addr = B + 10'd7; wdata = 8'hAA; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
    rd(B + 10'd6, v);  chk("R10 edge beats clear", v, 8'h04);
    wr(B + 10'd7, 8'hAA);
    rd(B + 10'd6, v);  chk("R7 clear with line high", v, 8'h00);
    chk("R11 irq low after clear", {7'b0, irq}, 8'h00);
    rd(B + 10'd0, v);  chk("R3 root empty", v, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule